// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a free-running 64-bit count that advances at a fixed nominal rate, 6.144 MHz in the intended use, while its clock comes from a faster system clock whose frequency depends on the board. It does this by adding a programmable numerator to a 13-bit phase accumulator on every system clock. Whenever the sum reaches a programmable denominator, the denominator is subtracted and the count goes up by one. The long-run count rate is therefore the clock rate times numerator over denominator. The result is exact even when the clock ratio is not an integer, with an error of less than one count at any moment.

Typical settings are 4/25 at 38.4 MHz, 64/125 at 12 MHz, 8/25 at 19.2 MHz, 192/625 at 20 MHz and 256/1125 at 27 MHz. When the low-speed reference is itself derived from the system clock divided by 610, the setting is 75/244. Software writes the two ratio values through a single write port. Each value sits in the low 12 bits of its own 32-bit register. The upper 20 bits of each register are a reserved field that keeps a fixed pattern and is never changed by a write.

Top module: `frac_master_ctr`

## Requirements
- R1: While reset is held and at the first cycle after it, `count_o` is 0 and `cfg_err_o` is 0. The ratio fields read numerator 4 and denominator 25, and bits 31:12 of both registers read the reserved pattern.
- R2: On every clock with a valid ratio and no write, the accumulator gains the numerator. If the sum is at or above the denominator, the denominator is subtracted and `count_o` rises by one. Starting from a cleared accumulator, exactly `num` counts occur in `den` clocks.
- R3: The count rises by at most one per clock. With numerator equal to denominator, it rises on every clock.
- R4: A write with `cfg_sel_i` = 0 loads `cfg_wdata_i[11:0]` into the numerator field, and `cfg_sel_i` = 1 loads the denominator field. Bits 31:12 of the write data are ignored, and bits 31:12 of both registers keep the reserved pattern.
- R5: A write to either register clears the accumulator. The count keeps its value through the write cycle.
- R6: A numerator of zero is a configuration error. `cfg_err_o` reads 1 and the count holds.
- R7: A numerator greater than the denominator is a configuration error with the same effect. Once a valid ratio is written, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Write strobe for a ratio register |
| cfg_sel_i | input | 1 | Register select: 0 numerator, 1 denominator |
| cfg_wdata_i | input | 32 | Write data; only bits 11:0 are used |
| num_reg_o | output | 32 | Numerator register: reserved bits 31:12, numerator in 11:0 |
| den_reg_o | output | 32 | Denominator register: reserved bits 31:12, denominator in 11:0 |
| count_o | output | 64 | Master count |
| cfg_err_o | output | 1 | High while the programmed ratio is invalid |

## Verification
The bench steps through every listed clock ratio and checks that exactly `num` counts land in `den` clocks after each reprogramming. A design that compared with `>` instead of `>=`, or that failed to clear the accumulator on a write, would be off by one or more counts there. Numerator equal to denominator is driven to catch a design that needs an extra cycle per carry. Zero and over-range numerators check that the count freezes and then resumes from the frozen value. A write carrying set upper data bits checks that the reserved field is left alone.

// File: rtl/frac_ctr_pkg.sv
package frac_ctr_pkg;
    localparam int unsigned FIELD_W = 12;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned CNT_W   = 64;

    typedef enum logic {
        SEL_NUM = 1'b0,
        SEL_DEN = 1'b1
    } ratio_sel_e;
endpackage

// File: rtl/frac_ratio_regs.sv
module frac_ratio_regs #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned FIELD_W = 12,
    parameter logic [REG_W-FIELD_W-1:0] RSVD_VAL = '0,
    parameter logic [FIELD_W-1:0] NUM_RST = 4,
    parameter logic [FIELD_W-1:0] DEN_RST = 25
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic               sel_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [FIELD_W-1:0] num_o,
    output logic [FIELD_W-1:0] den_o,
    output logic [REG_W-1:0]   num_reg_o,
    output logic [REG_W-1:0]   den_reg_o
);
    import frac_ctr_pkg::*;

    typedef struct packed {
        logic [FIELD_W-1:0] num;
        logic [FIELD_W-1:0] den;
    } ratio_t;

    ratio_t ratio_d, ratio_q;

    // Upper data bits carry no meaning for this block.
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[REG_W-1:FIELD_W];

    always_comb begin
        ratio_d = ratio_q;
        if (we_i) begin
            if (ratio_sel_e'(sel_i) == SEL_NUM) begin
                ratio_d.num = wdata_i[FIELD_W-1:0];
            end else begin
                ratio_d.den = wdata_i[FIELD_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ratio_q.num <= NUM_RST;
            ratio_q.den <= DEN_RST;
        end else begin
            ratio_q <= ratio_d;
        end
    end

    assign num_o     = ratio_q.num;
    assign den_o     = ratio_q.den;
    assign num_reg_o = {RSVD_VAL, ratio_q.num};
    assign den_reg_o = {RSVD_VAL, ratio_q.den};
endmodule

// File: rtl/frac_phase_step.sv
module frac_phase_step #(
    parameter int unsigned FIELD_W = 12,
    localparam int unsigned ACC_W  = FIELD_W + 1
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [FIELD_W-1:0] num_i,
    input  logic [FIELD_W-1:0] den_i,
    output logic [ACC_W-1:0]   acc_o,
    output logic               carry_o
);
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] den_ext;

    always_comb begin
        den_ext = {1'b0, den_i};
        sum     = acc_i + {1'b0, num_i};
        carry_o = (sum >= den_ext);
        acc_o   = carry_o ? (sum - den_ext) : sum;
    end
endmodule

// File: rtl/frac_master_ctr.sv
module frac_master_ctr #(
    parameter int unsigned REG_W   = frac_ctr_pkg::REG_W,
    parameter int unsigned FIELD_W = frac_ctr_pkg::FIELD_W,
    parameter int unsigned CNT_W   = frac_ctr_pkg::CNT_W,
    parameter logic [REG_W-FIELD_W-1:0] RSVD_VAL = 20'h5A5A5,
    parameter logic [FIELD_W-1:0] NUM_RST = 4,
    parameter logic [FIELD_W-1:0] DEN_RST = 25
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    output logic [REG_W-1:0] num_reg_o,
    output logic [REG_W-1:0] den_reg_o,
    output logic [CNT_W-1:0] count_o,
    output logic             cfg_err_o
);
    localparam int unsigned ACC_W = FIELD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t state_d, state_q;

    logic [FIELD_W-1:0] num;
    logic [FIELD_W-1:0] den;
    logic [ACC_W-1:0]   acc_step;
    logic               carry;
    logic               bad_ratio;

    frac_ratio_regs #(
        .REG_W   (REG_W),
        .FIELD_W (FIELD_W),
        .RSVD_VAL(RSVD_VAL),
        .NUM_RST (NUM_RST),
        .DEN_RST (DEN_RST)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .sel_i    (cfg_sel_i),
        .wdata_i  (cfg_wdata_i),
        .num_o    (num),
        .den_o    (den),
        .num_reg_o(num_reg_o),
        .den_reg_o(den_reg_o)
    );

    frac_phase_step #(
        .FIELD_W(FIELD_W)
    ) i_step (
        .acc_i  (state_q.acc),
        .num_i  (num),
        .den_i  (den),
        .acc_o  (acc_step),
        .carry_o(carry)
    );

    // A zero step never advances; a step above the modulus would need two carries.
    assign bad_ratio = (num == '0) || (num > den);

    always_comb begin
        state_d = state_q;
        if (cfg_we_i) begin
            state_d.acc = '0;
        end else if (!bad_ratio) begin
            state_d.acc = acc_step;
            state_d.cnt = state_q.cnt + CNT_W'(carry);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o   = state_q.cnt;
    assign cfg_err_o = bad_ratio;
endmodule

// File: rtl/frac_master_ctr_chk.sv
module frac_master_ctr_chk #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned FIELD_W = 12,
    parameter int unsigned CNT_W   = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_we_i,
    input logic [REG_W-1:0] num_reg_o,
    input logic [REG_W-1:0] den_reg_o,
    input logic [CNT_W-1:0] count_o,
    input logic             cfg_err_o,
    input logic [FIELD_W:0] acc
);
    logic [FIELD_W-1:0] num_f;
    logic [FIELD_W-1:0] den_f;
    assign num_f = num_reg_o[FIELD_W-1:0];
    assign den_f = den_reg_o[FIELD_W-1:0];

    AST_STEP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R3

    AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_we_i && !cfg_err_o && num_f == den_f) |=> count_o == $past(count_o) + 1'b1); // R3

    AST_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> count_o == $past(count_o)); // R5

    AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> count_o == $past(count_o)); // R6

    AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_err_o |-> acc < {1'b0, den_f}); // R2
endmodule

bind frac_master_ctr frac_master_ctr_chk #(
    .REG_W  (REG_W),
    .FIELD_W(FIELD_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .num_reg_o(num_reg_o),
    .den_reg_o(den_reg_o),
    .count_o  (count_o),
    .cfg_err_o(cfg_err_o),
    .acc      (state_q.acc)
);

// File: tb/test_frac_master_ctr.sv
module test_frac_master_ctr;
    localparam logic [19:0] RSVD = 20'h5A5A5;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_sel_i = 1'b0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] num_reg_o, den_reg_o;
    logic [63:0] count_o;
    logic        cfg_err_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int              m_num = 4, m_den = 25, m_acc = 0;
    longint unsigned m_cnt = 0;

    frac_master_ctr #(.RSVD_VAL(RSVD)) i_frac_master_ctr (
        .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .num_reg_o(num_reg_o), .den_reg_o(den_reg_o),
        .count_o(count_o), .cfg_err_o(cfg_err_o)
    );

    always #10 clk_i = ~clk_i;

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_bad();
        return (m_num == 0) || (m_num > m_den);
    endfunction

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_num = 4; m_den = 25; m_acc = 0; m_cnt = 0;
        end else if (cfg_we_i) begin
            if (cfg_sel_i) m_den = int'(cfg_wdata_i & 32'hFFF);
            else           m_num = int'(cfg_wdata_i & 32'hFFF);
            m_acc = 0;
        end else if (!m_bad()) begin
            m_acc = m_acc + m_num;
            if (m_acc >= m_den) begin
                m_acc = m_acc - m_den;
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk_i) begin
        cycles++;
        if (rst_ni && !done) begin
            check("R2 count", count_o, m_cnt);
            check("R6/R7 err", cfg_err_o, m_bad());
            check("R4 num field", num_reg_o[11:0], m_num);
            check("R4 den field", den_reg_o[11:0], m_den);
        end
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_we_i = 1'b0; cfg_wdata_i = '0;
    endtask

    // From a cleared accumulator, den clocks give exactly num counts (R2)
    task automatic span(input int n, input int d);
        longint unsigned c0;
        c0 = count_o;
        repeat (d) @(negedge clk_i);
        check("R2 span", count_o - c0, longint'(n));
    endtask

    initial begin
        longint unsigned held;
        repeat (3) @(negedge clk_i);
        // R1: state under reset and just after release
        check("R1 count", count_o, 0);
        check("R1 err", cfg_err_o, 0);
        check("R1 num reg", num_reg_o, {RSVD, 12'd4});
        check("R1 den reg", den_reg_o, {RSVD, 12'd25});
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 count after release", count_o, 0);

        repeat (249) @(negedge clk_i);
        check("R2 4/25 over 250", count_o, 40);

        // R5: write mid-run holds the count
        held = count_o;
        wr(1'b1, 32'd125);
        check("R5 count through write", count_o, held);
        wr(1'b0, 32'd64);  span(64, 125);
        wr(1'b1, 32'd25);  wr(1'b0, 32'd8);    span(8, 25);
        wr(1'b1, 32'd625); wr(1'b0, 32'd192);  span(192, 625);
        wr(1'b1, 32'd1125); wr(1'b0, 32'd256); span(256, 1125);
        wr(1'b0, 32'd75);  wr(1'b1, 32'd244);  span(75, 244);

        // R4: upper data bits ignored, reserved field kept
        wr(1'b0, 32'hFFFFF04B);
        check("R4 num reg", num_reg_o, {RSVD, 12'h04B});
        check("R4 den reg", den_reg_o, {RSVD, 12'd244});

        // R3: full rate when num == den
        wr(1'b0, 32'd244);
        span(244, 244);

        // R6: zero numerator freezes the count
        wr(1'b0, 32'd0);
        held = count_o;
        check("R6 err", cfg_err_o, 1);
        repeat (20) @(negedge clk_i);
        check("R6 held", count_o, held);

        // R7: numerator above denominator, then recovery
        wr(1'b0, 32'd300);
        check("R7 err", cfg_err_o, 1);
        repeat (20) @(negedge clk_i);
        check("R7 held", count_o, held);
        wr(1'b1, 32'd400);
        check("R7 err cleared", cfg_err_o, 0);
        check("R7 resume from held", count_o, held);
        span(300, 400);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule